// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block produces an active-low interrupt request whose rate and waveform are chosen by a 3-bit select field. It relies on timekeeping logic for two kinds of input. The first is a 2 Hz square-wave phase. The second is a set of single-cycle strobes that mark a new second, a new minute (at 00 seconds), a new hour (at 00:00) and a new month (00:00:00 on day 1).

Two waveform families are available:

- **Pulse modes** give a free-running 50% square wave at 2 Hz or 1 Hz. Its asserting edge lines up with the seconds strobe.
- **Level modes** pull the request low once per second, minute, hour or month. The request stays low until the host writes 0 to the status flag. That write releases the line only until the next period.

The status flag reads 1 exactly when this block is pulling its request low. The periodic request is ANDed with an active-low alarm request onto one shared line.

Top module: `pint_gen`

## Requirements
- R1: After reset the select field reads 000, the flag reads 0 and `irq_n` equals `alm_irq_n`.
- R2: Select 000 (off) and the reserved code 111 keep the flag at 0, whatever the strobes and the 2 Hz phase do.
- R3: Select 001 (2 Hz pulse): one cycle after `hz2_ph` is sampled low, the flag is 1. One cycle after it is sampled high, the flag is 0.
- R4: Select 010 (1 Hz pulse): the flag becomes 1 one cycle after `sec_stb`. It returns to 0 one cycle after the next falling edge of `hz2_ph` that does not coincide with `sec_stb`.
- R5: In the level modes only the matching strobe sets the flag, one cycle later. The codes are 011 for seconds, 100 for minutes, 101 for hours and 110 for months. The other strobes leave the flag at 0.
- R6: In a level mode the flag stays 1 until a flag write with data 0 clears it. A flag write with data 1 has no effect.
- R7: In the pulse modes a flag write has no effect on the flag or the waveform.
- R8: In a level mode, a period strobe and a clear write in the same cycle leave the flag at 1.
- R9: A select write updates `sel_rd` on the next cycle and forces the flag to 0 there, even if a strobe arrives in the same cycle.
- R10: `flag_rd` = 1 implies `irq_n` = 0. `irq_n` is the AND of the periodic request (active low) and `alm_irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hz2_ph | input | 1 | 2 Hz square-wave phase, low half asserts |
| sec_stb | input | 1 | One-cycle strobe at each new second |
| min_stb | input | 1 | One-cycle strobe at 00 seconds |
| hour_stb | input | 1 | One-cycle strobe at 00:00 of each hour |
| mon_stb | input | 1 | One-cycle strobe at 00:00:00 on day 1 |
| sel_wr | input | 1 | Select-field write strobe |
| sel_wdata | input | SEL_W | Select-field write data |
| flag_wr | input | 1 | Status-flag write strobe |
| flag_wdata | input | 1 | Status-flag write data (only 0 acts) |
| alm_irq_n | input | 1 | Active-low alarm request to merge |
| sel_rd | output | SEL_W | Select-field read data |
| flag_rd | output | 1 | Status flag: periodic request asserted |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The bench targets the places where the level and pulse families behave differently.

- **Clear write in pulse mode.** A design that honoured the clear there would chop the square wave short.
- **Clear arriving with a strobe.** A clear in the same cycle as a period strobe must lose. A design that let it win would miss a whole period.
- **Reserved code 111.** A design that decoded it as a level source would assert spuriously.
- **Select write against a strobe.** A select write must cancel an assertion even when a strobe arrives with it. A design that kept a stale assertion would leave the line held low under the new rate.
- **1 Hz release edge.** The 1 Hz wave must fall back only on the mid-second phase edge. A design that released on every phase edge would run at 2 Hz.

// File: rtl/pint_pkg.sv
package pint_pkg;
   localparam int unsigned CODE_OFF  = 0;
   localparam int unsigned CODE_FAST = 1;
   localparam int unsigned CODE_SLOW = 2;

   typedef enum logic [1:0] {
      MODE_OFF,
      MODE_FAST,
      MODE_SLOW,
      MODE_LEVEL
   } mode_e;
endpackage

// File: rtl/pint_phase.sv
// Derives the 2 Hz and 1 Hz asserting levels from the phase input and the seconds strobe.
module pint_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic hz2_ph,
   input  logic sec_stb,
   output logic fast_low_d,
   output logic slow_low_d
);
   logic hz2_q;
   logic slow_q;
   logic hz2_fall;

   assign hz2_fall   = hz2_q & ~hz2_ph;
   assign fast_low_d = ~hz2_ph;

   always_comb begin
      if (sec_stb)       slow_low_d = 1'b1;
      else if (hz2_fall) slow_low_d = 1'b0;
      else               slow_low_d = slow_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hz2_q  <= 1'b0;
         slow_q <= 1'b0;
      end else begin
         hz2_q  <= hz2_ph;
         slow_q <= slow_low_d;
      end
   end
endmodule

// File: rtl/pint_evsel.sv
// Decodes the select field into a mode and picks the strobe of the active level source.
module pint_evsel
   import pint_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned LVL_BASE = 3,
   parameter int unsigned LVL_N    = 4
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [LVL_N-1:0] lvl_stb,
   output mode_e            mode,
   output logic             lvl_evt
);
   logic [LVL_N-1:0] is_lvl;
   logic [LVL_N-1:0] hit;

   for (genvar i = 0; i < LVL_N; i++) begin : g_src
      assign is_lvl[i] = (sel == SEL_W'(LVL_BASE + i));
      assign hit[i]    = is_lvl[i] & lvl_stb[i];
   end

   assign lvl_evt = |hit;

   always_comb begin
      if (|is_lvl)                       mode = MODE_LEVEL;
      else if (sel == SEL_W'(CODE_FAST)) mode = MODE_FAST;
      else if (sel == SEL_W'(CODE_SLOW)) mode = MODE_SLOW;
      else                               mode = MODE_OFF;
   end
endmodule

// File: rtl/pint_core.sv
// Holds the select field and the registered asserting state of the periodic request.
module pint_core
   import pint_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter bit          CLR_WINS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic             flag_wr,
   input  logic             flag_wdata,
   input  mode_e            mode,
   input  logic             lvl_evt,
   input  logic             fast_low_d,
   input  logic             slow_low_d,
   output logic [SEL_W-1:0] sel_q,
   output logic             low_q
);
   logic clr_req;
   logic lvl_d;
   logic low_d;

   assign clr_req = flag_wr & ~flag_wdata;

   if (CLR_WINS) begin : g_clr_first
      assign lvl_d = clr_req ? 1'b0 : (lvl_evt ? 1'b1 : low_q);
   end else begin : g_evt_first
      assign lvl_d = lvl_evt ? 1'b1 : (clr_req ? 1'b0 : low_q);
   end

   always_comb begin
      unique case (mode)
         MODE_FAST:  low_d = fast_low_d;
         MODE_SLOW:  low_d = slow_low_d;
         MODE_LEVEL: low_d = lvl_d;
         default:    low_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         low_q <= 1'b0;
      end else if (sel_wr) begin
         sel_q <= sel_wdata;
         low_q <= 1'b0;
      end else begin
         low_q <= low_d;
      end
   end
endmodule

// File: rtl/pint_gen.sv
module pint_gen
   import pint_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned LVL_BASE = 3,
   parameter bit          CLR_WINS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hz2_ph,
   input  logic             sec_stb,
   input  logic             min_stb,
   input  logic             hour_stb,
   input  logic             mon_stb,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic             flag_wr,
   input  logic             flag_wdata,
   input  logic             alm_irq_n,
   output logic [SEL_W-1:0] sel_rd,
   output logic             flag_rd,
   output logic             irq_n
);
   localparam int unsigned LVL_N = 4;

   if (LVL_BASE + LVL_N > (1 << SEL_W)) begin : g_bad_width
      $error("pint_gen: select field too narrow for level codes");
   end
   if (LVL_BASE <= CODE_SLOW) begin : g_bad_base
      $error("pint_gen: level codes overlap pulse codes");
   end

   mode_e            mode;
   logic             lvl_evt;
   logic             fast_low_d;
   logic             slow_low_d;
   logic [SEL_W-1:0] sel_q;
   logic             low_q;

   pint_phase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .hz2_ph     (hz2_ph),
      .sec_stb    (sec_stb),
      .fast_low_d (fast_low_d),
      .slow_low_d (slow_low_d)
   );

   pint_evsel #(
      .SEL_W    (SEL_W),
      .LVL_BASE (LVL_BASE),
      .LVL_N    (LVL_N)
   ) u_evsel (
      .sel     (sel_q),
      .lvl_stb ({mon_stb, hour_stb, min_stb, sec_stb}),
      .mode    (mode),
      .lvl_evt (lvl_evt)
   );

   pint_core #(
      .SEL_W    (SEL_W),
      .CLR_WINS (CLR_WINS)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_wr     (sel_wr),
      .sel_wdata  (sel_wdata),
      .flag_wr    (flag_wr),
      .flag_wdata (flag_wdata),
      .mode       (mode),
      .lvl_evt    (lvl_evt),
      .fast_low_d (fast_low_d),
      .slow_low_d (slow_low_d),
      .sel_q      (sel_q),
      .low_q      (low_q)
   );

   assign sel_rd  = sel_q;
   assign flag_rd = low_q;
   assign irq_n   = ~low_q & alm_irq_n;
endmodule

// File: rtl/pint_gen_chk.sv
module pint_gen_chk #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned LVL_BASE = 3,
   parameter bit          CLR_WINS = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hz2_ph,
   input logic             sec_stb,
   input logic             min_stb,
   input logic             hour_stb,
   input logic             mon_stb,
   input logic             sel_wr,
   input logic [SEL_W-1:0] sel_wdata,
   input logic             flag_wr,
   input logic             flag_wdata,
   input logic             alm_irq_n,
   input logic [SEL_W-1:0] sel_rd,
   input logic             flag_rd,
   input logic             irq_n
);
   logic ck_lvl;
   logic ck_evt;
   logic ck_clr;
   logic ck_off;

   always_comb begin
      ck_lvl = (int'(sel_rd) >= LVL_BASE) && (int'(sel_rd) < LVL_BASE + 4);
      ck_evt = ((int'(sel_rd) == LVL_BASE)     && sec_stb)  ||
               ((int'(sel_rd) == LVL_BASE + 1) && min_stb)  ||
               ((int'(sel_rd) == LVL_BASE + 2) && hour_stb) ||
               ((int'(sel_rd) == LVL_BASE + 3) && mon_stb);
      ck_clr = flag_wr && !flag_wdata;
      ck_off = (int'(sel_rd) == 0) || (&sel_rd);
   end

   // R10
   flag_drives_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_rd |-> !irq_n);
   // R10
   alarm_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alm_irq_n |-> !irq_n);
   // R2
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ck_off |-> !flag_rd);
   // R9
   sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (!flag_rd && sel_rd == $past(sel_wdata)));
   // R3
   fast_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_rd) == 1 && !sel_wr && !hz2_ph) |=> flag_rd);
   // R3
   fast_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_rd) == 1 && !sel_wr && hz2_ph) |=> !flag_rd);
   // R4
   slow_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_rd) == 2 && !sel_wr && sec_stb) |=> flag_rd);
   // R5 R8
   level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_lvl && !sel_wr && ck_evt && (!CLR_WINS || !ck_clr)) |=> flag_rd);
   // R5
   level_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_lvl && !sel_wr && !flag_rd && !ck_evt) |=> !flag_rd);
   // R6
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_lvl && !sel_wr && flag_rd && !ck_clr) |=> flag_rd);
   // R6
   level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ck_lvl && !sel_wr && ck_clr && !ck_evt) |=> !flag_rd);
endmodule

bind pint_gen pint_gen_chk #(
   .SEL_W    (SEL_W),
   .LVL_BASE (LVL_BASE),
   .CLR_WINS (CLR_WINS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hz2_ph     (hz2_ph),
   .sec_stb    (sec_stb),
   .min_stb    (min_stb),
   .hour_stb   (hour_stb),
   .mon_stb    (mon_stb),
   .sel_wr     (sel_wr),
   .sel_wdata  (sel_wdata),
   .flag_wr    (flag_wr),
   .flag_wdata (flag_wdata),
   .alm_irq_n  (alm_irq_n),
   .sel_rd     (sel_rd),
   .flag_rd    (flag_rd),
   .irq_n      (irq_n)
);

// File: tb/pint_gen_bench.sv
module pint_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hz2_ph = 1'b1;
   logic       sec_stb = 1'b0;
   logic       min_stb = 1'b0;
   logic       hour_stb = 1'b0;
   logic       mon_stb = 1'b0;
   logic       sel_wr = 1'b0;
   logic [2:0] sel_wdata = 3'd0;
   logic       flag_wr = 1'b0;
   logic       flag_wdata = 1'b0;
   logic       alm_irq_n = 1'b1;
   logic [2:0] sel_rd;
   logic       flag_rd;
   logic       irq_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   pint_gen u_pint_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .hz2_ph     (hz2_ph),
      .sec_stb    (sec_stb),
      .min_stb    (min_stb),
      .hour_stb   (hour_stb),
      .mon_stb    (mon_stb),
      .sel_wr     (sel_wr),
      .sel_wdata  (sel_wdata),
      .flag_wr    (flag_wr),
      .flag_wdata (flag_wdata),
      .alm_irq_n  (alm_irq_n),
      .sel_rd     (sel_rd),
      .flag_rd    (flag_rd),
      .irq_n      (irq_n)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_stb(input int idx, input logic v);
      case (idx)
         0: sec_stb  = v;
         1: min_stb  = v;
         2: hour_stb = v;
         default: mon_stb = v;
      endcase
   endtask

   task automatic pulse_stb(input int idx);
      set_stb(idx, 1'b1);
      step();
      set_stb(idx, 1'b0);
   endtask

   task automatic write_sel(input logic [2:0] v);
      sel_wr = 1'b1; sel_wdata = v;
      step();
      sel_wr = 1'b0;
   endtask

   task automatic write_flag(input logic v);
      flag_wr = 1'b1; flag_wdata = v;
      step();
      flag_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 sel after reset", int'(sel_rd), 0);
      chk("R1 flag after reset", int'(flag_rd), 0);
      chk("R1 irq_n after reset", int'(irq_n), 1);
   endtask

   task automatic t_off();
      logic [2:0] codes [2] = '{3'd0, 3'd7};
      foreach (codes[c]) begin
         write_sel(codes[c]);
         for (int i = 0; i < 4; i++) begin
            pulse_stb(i);
            chk("R2 off strobe", int'(flag_rd), 0);
         end
         hz2_ph = 1'b0; step();
         chk("R2 off phase low", int'(flag_rd), 0);
         hz2_ph = 1'b1; step();
         chk("R2 off irq_n", int'(irq_n), 1);
      end
   endtask

   task automatic t_fast();
      write_sel(3'd1);
      chk("R3 fast phase high", int'(flag_rd), 0);
      hz2_ph = 1'b0; step();
      chk("R3 fast phase low", int'(flag_rd), 1);
      chk("R10 line low with flag", int'(irq_n), 0);
      write_flag(1'b0);
      chk("R7 fast clear ignored", int'(flag_rd), 1);
      hz2_ph = 1'b1; step();
      chk("R3 fast release", int'(flag_rd), 0);
      chk("R10 line high", int'(irq_n), 1);
   endtask

   task automatic t_slow();
      write_sel(3'd2);
      hz2_ph = 1'b0; sec_stb = 1'b1; step();
      sec_stb = 1'b0;
      chk("R4 slow start", int'(flag_rd), 1);
      write_flag(1'b0);
      chk("R7 slow clear ignored", int'(flag_rd), 1);
      step();
      hz2_ph = 1'b1; step();
      chk("R4 slow hold across rise", int'(flag_rd), 1);
      hz2_ph = 1'b0; step();
      chk("R4 slow release at mid fall", int'(flag_rd), 0);
      hz2_ph = 1'b1; step();
      chk("R4 slow stays released", int'(flag_rd), 0);
      hz2_ph = 1'b0; sec_stb = 1'b1; step();
      sec_stb = 1'b0;
      chk("R4 slow restart", int'(flag_rd), 1);
      hz2_ph = 1'b1; step();
   endtask

   task automatic t_level();
      for (int k = 0; k < 4; k++) begin
         write_sel(3'(3 + k));
         chk("R9 sel readback", int'(sel_rd), 3 + k);
         for (int j = 0; j < 4; j++) begin
            if (j != k) begin
               pulse_stb(j);
               chk("R5 other strobe ignored", int'(flag_rd), 0);
            end
         end
         pulse_stb(k);
         chk("R5 matching strobe sets", int'(flag_rd), 1);
         step(); step();
         chk("R6 sticky", int'(flag_rd), 1);
         write_flag(1'b1);
         chk("R6 write 1 ignored", int'(flag_rd), 1);
         write_flag(1'b0);
         chk("R6 write 0 clears", int'(flag_rd), 0);
         chk("R6 line released", int'(irq_n), 1);
      end
   endtask

   task automatic t_collide();
      write_sel(3'd3);
      pulse_stb(0);
      sec_stb = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0; step();
      sec_stb = 1'b0; flag_wr = 1'b0;
      chk("R8 strobe beats clear while set", int'(flag_rd), 1);
      write_flag(1'b0);
      sec_stb = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0; step();
      sec_stb = 1'b0; flag_wr = 1'b0;
      chk("R8 strobe beats clear while idle", int'(flag_rd), 1);
   endtask

   task automatic t_selchg();
      chk("R9 precondition set", int'(flag_rd), 1);
      write_sel(3'd4);
      chk("R9 select change clears", int'(flag_rd), 0);
      chk("R9 new select read", int'(sel_rd), 4);
      pulse_stb(0);
      chk("R9 old source dropped", int'(flag_rd), 0);
      sel_wr = 1'b1; sel_wdata = 3'd3; sec_stb = 1'b1; step();
      sel_wr = 1'b0; sec_stb = 1'b0;
      chk("R9 write beats strobe", int'(flag_rd), 0);
   endtask

   task automatic t_alarm();
      write_sel(3'd0);
      alm_irq_n = 1'b0; step();
      chk("R10 alarm drives line", int'(irq_n), 0);
      chk("R10 flag ignores alarm", int'(flag_rd), 0);
      alm_irq_n = 1'b1; step();
      chk("R10 alarm release", int'(irq_n), 1);
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_off();
      t_fast();
      t_slow();
      t_level();
      t_collide();
      t_selchg();
      t_alarm();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL all watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule